// File: doc/BRIEF.md
# I2C Multi-Master Control and Status Register

This block is the control and status byte of a multi-master I2C controller. It sits between a simple CPU register port and an I2C byte engine. The register port has write and read strobes and 8-bit data. The block holds the transfer mode and the serial enable, and passes both straight to the engine. A CPU write to the busy position does not store a value. Instead it becomes a one-cycle START or STOP request to the engine. After an accepted START, the engine sends the byte that is waiting in its data register without any further CPU action.

A bus monitor samples the SCL and SDA lines through a synchronizer. It detects START and STOP conditions and keeps a bus-busy status that the CPU reads back. The engine reports three kinds of status events:
- lost arbitration,
- a received slave address byte,
- a received bit.

Each status event sets its own flag, and each flag has its own rule for being cleared. The CPU cannot write the status flags.

Top module: `i2c_ctlstat_reg`

## Requirements
- R1: After reset, every bit of `rdata` is 0 and neither `start_req` nor `stop_req` is asserted.
- R2: A write stores `wdata[7:6]` as the mode and `wdata[4]` as the serial enable, visible on `rdata` and on `mode`/`txrx_en` from the next cycle. The mode encoding is 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit.
- R3: A write with `wdata[5]`=1 while the bus is idle (`rdata[5]`=0) produces a `start_req` pulse of exactly one cycle in the cycle after the write. It also clears the arbitration flag.
- R4: A write with `wdata[5]`=0 produces a `stop_req` pulse of exactly one cycle in the cycle after the write. `start_req` and `stop_req` are never high together.
- R5: A write with `wdata[5]`=1 while the bus is busy produces no `start_req`. It sets the arbitration flag `rdata[3]` in the next cycle.
- R6: A START (SDA falls while SCL is high) sets `rdata[5]`, and a STOP (SDA rises while SCL is high) clears it. The lines pass through a two-flop synchronizer, so `rdata[5]` changes at the third rising clock edge after the line change.
- R7: An `arb_lost` pulse sets `rdata[3]` in the next cycle. Only an accepted START request clears it, and a set in the same cycle wins over that clear.
- R8: An `addr_valid` pulse whose `addr_byte[7:1]` equals `own_addr` sets `rdata[2]`. The flag clears in the cycle after an `rd_en` strobe. A set in the same cycle wins over the clear.
- R9: An `addr_valid` pulse with `addr_byte` equal to 0 sets `rdata[1]`. A detected START or STOP clears it. A set in the same cycle wins over the clear.
- R10: An `rx_valid` pulse loads `rx_bit` into `rdata[0]` (0 = ACK, 1 = no ACK). Without `rx_valid`, `rdata[0]` holds its value.
- R11: Writes have no effect on `rdata[3:0]`. The written value of `wdata[5]` is never stored in `rdata[5]`.
- R12: The read layout is `rdata` = {mode[1:0], busy, enable, arbitration, address match, address zero, last bit}, from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for the register |
| rd_en | input | 1 | CPU read strobe for the register |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Register read value |
| own_addr | input | 7 | Programmed own slave address |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| arb_lost | input | 1 | Engine pulse: arbitration lost |
| addr_valid | input | 1 | Engine pulse: slave address byte received |
| addr_byte | input | 8 | Received slave address byte |
| rx_valid | input | 1 | Engine pulse: a bit was received |
| rx_bit | input | 1 | Value of the received bit |
| start_req | output | 1 | One-cycle START request to the engine |
| stop_req | output | 1 | One-cycle STOP request to the engine |
| mode | output | 2 | Current transfer mode to the engine |
| txrx_en | output | 1 | Serial transmit/receive enable to the engine |

## Verification
The properties check the following on every cycle:
- each request pulse traces back to the write that caused it, and the two pulses stay exclusive,
- a START attempt while the bus is busy is refused and flags lost arbitration,
- mode and enable follow the last write,
- the match flag drops after a read and the last-bit flag holds between received bits,
- busy only rises after a detected START.

Only the bench's scenarios can show the full timing of the synchronizer, because they drive real line sequences. The same goes for flag priorities when a set and a clear fall in the same cycle, for the zero flag being cleared by bus conditions, and for writes leaving the status bits untouched. A behavioural model in the bench follows all of these under mixed random traffic.

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;
  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } i2c_mode_e;

  localparam int BIT_BUSY = 5;
  localparam int BIT_EN   = 4;

  typedef struct packed {
    logic arb;
    logic match;
    logic zero;
    logic last;
  } i2c_flags_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], raw_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign sync_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic [1:0] lines_s;
  logic [1:0] lines_prev_q;
  logic       busy_q;
  logic       busy_d;
  logic       scl_s;
  logic       sda_s;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_in, scl_in}),
    .sync_o (lines_s)
  );

  assign scl_s = lines_s[0];
  assign sda_s = lines_s[1];

  always_comb begin
    start_det = scl_s && lines_prev_q[0] && lines_prev_q[1] && !sda_s;
    stop_det  = scl_s && lines_prev_q[0] && !lines_prev_q[1] && sda_s;
    busy_d    = busy_q;
    if (start_det)     busy_d = 1'b1;
    else if (stop_det) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_prev_q <= 2'b11;
      busy_q       <= 1'b0;
    end else begin
      lines_prev_q <= lines_s;
      busy_q       <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/i2c_req_ctrl.sv
module i2c_req_ctrl
  import i2c_csr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wr_busy,
  input  logic      wr_en_bit,
  input  logic [1:0] wr_mode,
  input  logic      bus_busy,
  output i2c_mode_e mode_q,
  output logic      txrx_en_q,
  output logic      start_req_q,
  output logic      stop_req_q,
  output logic      start_accept,
  output logic      start_refuse
);
  logic start_req_d;
  logic stop_req_d;

  always_comb begin
    start_accept = wr_en && wr_busy && !bus_busy;
    start_refuse = wr_en && wr_busy && bus_busy;
    start_req_d  = start_accept;
    stop_req_d   = wr_en && !wr_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_SLV_RX;
      txrx_en_q   <= 1'b0;
      start_req_q <= 1'b0;
      stop_req_q  <= 1'b0;
    end else begin
      start_req_q <= start_req_d;
      stop_req_q  <= stop_req_d;
      if (wr_en) begin
        mode_q    <= i2c_mode_e'(wr_mode);
        txrx_en_q <= wr_en_bit;
      end
    end
  end
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2c_csr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_lost,
  input  logic              start_refuse,
  input  logic              start_accept,
  input  logic              addr_valid,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              rd_en,
  input  logic              bus_event,
  input  logic              rx_valid,
  input  logic              rx_bit,
  output i2c_flags_t        flags_q
);
  i2c_flags_t flags_d;
  logic       hit_own;
  logic       hit_zero;

  always_comb begin
    hit_own  = addr_valid && (addr_byte[ADDR_W:1] == own_addr);
    hit_zero = addr_valid && (addr_byte == '0);
    flags_d  = flags_q;

    if (arb_lost || start_refuse) flags_d.arb = 1'b1;
    else if (start_accept)        flags_d.arb = 1'b0;

    if (hit_own)    flags_d.match = 1'b1;
    else if (rd_en) flags_d.match = 1'b0;

    if (hit_zero)       flags_d.zero = 1'b1;
    else if (bus_event) flags_d.zero = 1'b0;

    if (rx_valid) flags_d.last = rx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/i2c_ctlstat_reg.sv
module i2c_ctlstat_reg
  import i2c_csr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              arb_lost,
  input  logic              addr_valid,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic              rx_valid,
  input  logic              rx_bit,
  output logic              start_req,
  output logic              stop_req,
  output logic [1:0]        mode,
  output logic              txrx_en
);
  logic       bus_start;
  logic       bus_stop;
  logic       bus_busy;
  logic       start_accept;
  logic       start_refuse;
  i2c_mode_e  mode_q;
  i2c_flags_t flags_q;
  logic       unused_wbits;

  assign unused_wbits = ^wdata[3:0];

  i2c_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .start_det (bus_start),
    .stop_det  (bus_stop),
    .busy      (bus_busy)
  );

  i2c_req_ctrl u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_busy      (wdata[BIT_BUSY]),
    .wr_en_bit    (wdata[BIT_EN]),
    .wr_mode      (wdata[7:6]),
    .bus_busy     (bus_busy),
    .mode_q       (mode_q),
    .txrx_en_q    (txrx_en),
    .start_req_q  (start_req),
    .stop_req_q   (stop_req),
    .start_accept (start_accept),
    .start_refuse (start_refuse)
  );

  i2c_status_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .arb_lost     (arb_lost),
    .start_refuse (start_refuse),
    .start_accept (start_accept),
    .addr_valid   (addr_valid),
    .addr_byte    (addr_byte),
    .own_addr     (own_addr),
    .rd_en        (rd_en),
    .bus_event    (bus_start || bus_stop),
    .rx_valid     (rx_valid),
    .rx_bit       (rx_bit),
    .flags_q      (flags_q)
  );

  assign mode  = mode_q;
  assign rdata = {mode_q, bus_busy, txrx_en, flags_q.arb, flags_q.match,
                  flags_q.zero, flags_q.last};
endmodule

// File: rtl/i2c_ctlstat_reg_chk.sv
module i2c_ctlstat_reg_chk #(
  parameter int ADDR_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [7:0]      wdata,
  input logic [7:0]      rdata,
  input logic            arb_lost,
  input logic            addr_valid,
  input logic [ADDR_W:0] addr_byte,
  input logic            rx_valid,
  input logic            start_req,
  input logic            stop_req,
  input logic            bus_start
);
  assert_start_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(wr_en && wdata[5] && !rdata[5]));

  assert_stop_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> $past(wr_en && !wdata[5]));

  assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_req && stop_req));

  assert_refused_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[5] && rdata[5]) |=> (rdata[3] && !start_req));

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[7:6] == $past(wdata[7:6]) && rdata[4] == $past(wdata[4])));

  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[5]) |-> $past(bus_start));

  assert_arb_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> rdata[3]);

  assert_match_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !addr_valid) |=> !rdata[2]);

  assert_zero_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_byte == '0) |=> rdata[1]);

  assert_last_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> rdata[0] == $past(rdata[0]));
endmodule

bind i2c_ctlstat_reg i2c_ctlstat_reg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .arb_lost   (arb_lost),
  .addr_valid (addr_valid),
  .addr_byte  (addr_byte),
  .rx_valid   (rx_valid),
  .start_req  (start_req),
  .stop_req   (stop_req),
  .bus_start  (bus_start)
);

// File: tb/sim_i2c_ctlstat_reg.sv
`timescale 1ns/1ps
module sim_i2c_ctlstat_reg;
  localparam logic [6:0] OWN = 7'h3A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       scl_in = 1'b1, sda_in = 1'b1;
  logic       arb_lost = 1'b0, addr_valid = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic       start_req, stop_req, txrx_en;
  logic [1:0] mode;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  // behavioural reference state
  bit [1:0] m_mode;
  bit m_busy, m_en, m_arb, m_match, m_zero, m_last, m_start, m_stop;
  bit sc[4];
  bit sd[4];

  always #4 clk = ~clk;

  i2c_ctlstat_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .own_addr(OWN), .scl_in(scl_in), .sda_in(sda_in),
    .arb_lost(arb_lost), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .start_req(start_req),
    .stop_req(stop_req), .mode(mode), .txrx_en(txrx_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", cycles, 100000);
      finish_run();
    end
  end

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_busy = 0; m_en = 0; m_arb = 0; m_match = 0;
      m_zero = 0; m_last = 0; m_start = 0; m_stop = 0;
      for (int i = 0; i < 4; i++) begin sc[i] = 1; sd[i] = 1; end
    end else begin
      bit st, sp, acc, rfs;
      for (int i = 3; i > 0; i--) begin sc[i] = sc[i-1]; sd[i] = sd[i-1]; end
      sc[0] = scl_in; sd[0] = sda_in;
      st  = sc[2] && sc[3] && sd[3] && !sd[2];
      sp  = sc[2] && sc[3] && !sd[3] && sd[2];
      acc = wr_en && wdata[5] && !m_busy;
      rfs = wr_en && wdata[5] && m_busy;
      m_start = acc;
      m_stop  = wr_en && !wdata[5];
      if (rfs || arb_lost) m_arb = 1; else if (acc) m_arb = 0;
      if (addr_valid && addr_byte[7:1] == OWN) m_match = 1; else if (rd_en) m_match = 0;
      if (addr_valid && addr_byte == 8'h00) m_zero = 1; else if (st || sp) m_zero = 0;
      if (rx_valid) m_last = rx_bit;
      if (wr_en) begin m_mode = wdata[7:6]; m_en = wdata[4]; end
      if (st) m_busy = 1; else if (sp) m_busy = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(rdata[7:6] == m_mode, "R2 mode", rdata[7:6], m_mode);
      chk(rdata[4] == m_en, "R2 enable", rdata[4], m_en);
      chk(mode == m_mode && txrx_en == m_en, "R2 engine outputs", {mode, txrx_en}, {m_mode, m_en});
      chk(rdata[5] == m_busy, "R6 busy", rdata[5], m_busy);
      chk(rdata[3] == m_arb, "R7 arb", rdata[3], m_arb);
      chk(rdata[2] == m_match, "R8 match", rdata[2], m_match);
      chk(rdata[1] == m_zero, "R9 zero", rdata[1], m_zero);
      chk(rdata[0] == m_last, "R10 last", rdata[0], m_last);
      chk(start_req == m_start, "R3 start_req", start_req, m_start);
      chk(stop_req == m_stop, "R4 stop_req", stop_req, m_stop);
      chk(rdata == {m_mode, m_busy, m_en, m_arb, m_match, m_zero, m_last},
          "R12 layout", rdata, {m_mode, m_busy, m_en, m_arb, m_match, m_zero, m_last});
    end
  end

  task automatic write_reg(input logic [7:0] v);
    wr_en = 1; wdata = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    cmp_on = 1;
    chk(rdata == 8'h00 && !start_req && !stop_req, "R1 reset", rdata, 0);

    // writes: mode 11, enable 1, busy bit 0, low bits all ones
    write_reg(8'hDF);
    chk(stop_req == 1, "R4 stop pulse", stop_req, 1);
    chk(rdata[3:0] == 4'h0 && rdata[5] == 0, "R11 write ignored", rdata, 8'hD0);
    chk(rdata[7:6] == 2'b11 && txrx_en, "R2 master tx", rdata, 8'hD0);
    @(negedge clk);
    chk(stop_req == 0, "R4 single cycle", stop_req, 0);

    // START request while idle
    write_reg(8'hF0);
    chk(start_req == 1, "R3 start pulse", start_req, 1);
    @(negedge clk);
    chk(start_req == 0, "R3 single cycle", start_req, 0);

    // START condition on the bus
    sda_in = 0;
    idle(2);
    chk(rdata[5] == 0, "R6 sync latency", rdata[5], 0);
    idle(1);
    chk(rdata[5] == 1, "R6 busy after START", rdata[5], 1);
    scl_in = 0;
    idle(2);

    // START request refused while busy
    write_reg(8'hB0);
    chk(start_req == 0 && rdata[3] == 1, "R5 refused start", {start_req, rdata[3]}, 1);

    // address match, read in same cycle, then read
    addr_valid = 1; addr_byte = {OWN, 1'b1}; rd_en = 1;
    @(negedge clk);
    addr_valid = 0; rd_en = 0;
    chk(rdata[2] == 1, "R8 set wins", rdata[2], 1);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk(rdata[2] == 0, "R8 cleared by read", rdata[2], 0);

    // general address zero, then STOP on bus
    addr_valid = 1; addr_byte = 8'h00;
    @(negedge clk);
    addr_valid = 0;
    chk(rdata[1] == 1, "R9 zero set", rdata[1], 1);
    sda_in = 0; scl_in = 1; idle(4);
    sda_in = 1; idle(4);
    chk(rdata[1] == 0 && rdata[5] == 0, "R9 zero cleared by STOP", rdata, 0);

    // received bits
    rx_valid = 1; rx_bit = 1; @(negedge clk); rx_valid = 0; rx_bit = 0;
    idle(2);
    chk(rdata[0] == 1, "R10 no ack held", rdata[0], 1);
    rx_valid = 1; @(negedge clk); rx_valid = 0;
    chk(rdata[0] == 0, "R10 ack", rdata[0], 0);

    // arbitration flag: set wins over accepted start clear, then clear
    arb_lost = 1; wr_en = 1; wdata = 8'h20;
    @(negedge clk);
    arb_lost = 0; wr_en = 0;
    chk(rdata[3] == 1 && start_req == 1, "R7 set wins", rdata[3], 1);
    write_reg(8'h20);
    chk(rdata[3] == 0, "R7 cleared by start", rdata[3], 0);

    // remaining modes
    write_reg(8'h00); chk(rdata[7:6] == 2'b00, "R2 slave rx", rdata[7:6], 0);
    write_reg(8'h40); chk(rdata[7:6] == 2'b01, "R2 slave tx", rdata[7:6], 1);
    write_reg(8'h90); chk(rdata[7:6] == 2'b10 && rdata[4], "R2 master rx", rdata, 8'h90);

    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      scl_in     = ($urandom % 4) != 0;
      sda_in     = ($urandom % 3) != 0;
      wr_en      = ($urandom % 8) == 0;
      wdata      = 8'($urandom);
      rd_en      = ($urandom % 6) == 0;
      arb_lost   = ($urandom % 20) == 0;
      addr_valid = ($urandom % 7) == 0;
      case ($urandom % 3)
        0: addr_byte = {OWN, 1'($urandom)};
        1: addr_byte = 8'h00;
        default: addr_byte = 8'($urandom);
      endcase
      rx_valid   = ($urandom % 5) == 0;
      rx_bit     = 1'($urandom);
      @(negedge clk);
    end
    wr_en = 0; rd_en = 0; arb_lost = 0; addr_valid = 0; rx_valid = 0;
    idle(4);
    finish_run();
  end
endmodule